// File: doc/BRIEF.md
# Transceiver Operating Mode Controller

This block sequences the operating mode of a single-wire bus transceiver. It watches a supply-good flag from an undervoltage comparator, the enable pin and the transmit pin from the host, and two already qualified wake pulses from a separate wake detector: one from the bus and one from a local switch. It then moves between four modes: powered off, fail-safe, normal and sleep. The block drives the regulator enable, the communication enable, a wake-request flag that pulls the receive pin low, and a source select that picks a strong or weak pull-down on the transmit pin.

Mode changes made through the enable pin are debounced by a time filter counted in microseconds. The microsecond is derived from the system clock, and the two directions of the filter have separate lengths. An enable pulse shorter than its window is discarded. The block has no data stream, so every pin is a plain level or a one-cycle pulse. All inputs are taken as already synchronous to `clk`.

Mode encoding on `mode`: 0 = off, 1 = fail-safe, 2 = normal, 3 = sleep.

Top module: `lmc_top`

## Requirements
- R1: While `rst_n` is low, and afterwards while `supply_ok` stays low, `mode` is 0 and `inh_on`, `comm_en`, `rxd_wake_low` and `txd_strong_pd` are all 0.
- R2: A cycle with `supply_ok` low puts `mode` to 0 at the next edge from any mode. It clears both wake flags and resets the enable filter to low.
- R3: In mode 0 with `supply_ok` high, the next edge enters fail-safe (mode 1). Fail-safe without a pending wake gives `inh_on`=1, `comm_en`=0, `rxd_wake_low`=0 and `txd_strong_pd`=0 (weak pull-down).
- R4: The filtered enable follows `en_pin` only after the pin has differed from it on NORM_US×CLK_PER_US consecutive edges (rising) or SLEEP_US×CLK_PER_US edges (falling). A shorter pulse changes no mode.
- R5: In fail-safe with the filtered enable high, the next edge enters normal (mode 2), with `inh_on`=1 and `comm_en`=1.
- R6: In normal, an accepted enable fall with `txd_pin` high enters sleep (mode 3) at the next edge, with `inh_on`=0 and `comm_en`=0. This does not depend on the wake inputs.
- R7: In normal, an accepted enable fall with `txd_pin` low leaves the mode at normal.
- R8: In sleep, `local_wake` enters fail-safe at the next edge with `rxd_wake_low`=1 and `txd_strong_pd`=1. It wins over a `bus_wake` in the same cycle.
- R9: In sleep, `bus_wake` alone enters fail-safe at the next edge with `rxd_wake_low`=1 and `txd_strong_pd`=0.
- R10: Both wake flags clear at the edge after `en_pin` is sampled high, without waiting for the filter.
- R11: Wake pulses outside sleep change neither the mode nor the wake flags.
- R12: In sleep, the enable pin causes no mode change, even when its level is accepted by the filter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| supply_ok | input | 1 | Supply above undervoltage threshold |
| en_pin | input | 1 | Host enable level |
| txd_pin | input | 1 | Host transmit level |
| bus_wake | input | 1 | Qualified remote wake pulse |
| local_wake | input | 1 | Qualified local wake pulse |
| inh_on | output | 1 | External regulator enable |
| comm_en | output | 1 | Transmit and receive paths active |
| rxd_wake_low | output | 1 | Drive receive pin low to signal a wake |
| txd_strong_pd | output | 1 | 1 = strong pull-down (local wake), 0 = weak |
| mode | output | 2 | Current mode, encoded as above |

## Verification
The supply, wake and flag-clear results appear one edge after the input is sampled. An accepted enable change reaches `mode` one edge after the filter's window closes, which is window length plus one edges after the first differing sample. Inputs change on the falling clock edge and outputs are compared on the following falling edges. A bench model keeps the same edge counts, so each directed check lands exactly one edge before or after the expected change. Random stimulus is compared every cycle against that model.

// File: rtl/lmc_pkg.sv
package lmc_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_SAFE = 2'd1,
    MODE_RUN  = 2'd2,
    MODE_DOZE = 2'd3
  } mode_e;
endpackage

// File: rtl/lmc_us_timer.sv
module lmc_us_timer #(
  parameter int CLK_PER_US = 250,
  parameter int MAX_US     = 15,
  localparam int PW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1,
  localparam int UW = $clog2(MAX_US + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [UW-1:0] lim_us,
  output logic          expire
);
  logic [PW-1:0] presc;
  logic [UW-1:0] us;
  logic          us_edge;

  assign us_edge = (presc == PW'(CLK_PER_US - 1));
  assign expire  = run && us_edge && (us == lim_us - UW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      presc <= '0;
      us    <= '0;
    end else if (!run || expire) begin
      presc <= '0;
      us    <= '0;
    end else if (us_edge) begin
      presc <= '0;
      us    <= us + UW'(1);
    end else begin
      presc <= presc + PW'(1);
    end
  end
endmodule

// File: rtl/lmc_en_filter.sv
module lmc_en_filter #(
  parameter int CLK_PER_US = 250,
  parameter int NORM_US    = 7,
  parameter int SLEEP_US   = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en_pin,
  output logic en_f,
  output logic en_fall
);
  localparam int MAXU = (NORM_US > SLEEP_US) ? NORM_US : SLEEP_US;
  localparam int UW   = $clog2(MAXU + 1);

  logic          run;
  logic          expire;
  logic [UW-1:0] lim;

  assign run = !clr && (en_pin != en_f);
  assign lim = en_f ? UW'(SLEEP_US) : UW'(NORM_US);

  lmc_us_timer #(.CLK_PER_US(CLK_PER_US), .MAX_US(MAXU)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .lim_us (lim),
    .expire (expire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      en_f    <= 1'b0;
      en_fall <= 1'b0;
    end else begin
      en_fall <= expire && !en_pin;
      if (expire) en_f <= en_pin;
    end
  end

  // R4
  en_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(en_f) && !$past(clr)) |-> $past(expire));
endmodule

// File: rtl/lmc_mode_fsm.sv
module lmc_mode_fsm
  import lmc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  supply_ok,
  input  logic  en_pin,
  input  logic  txd_pin,
  input  logic  en_f,
  input  logic  en_fall,
  input  logic  bus_wake,
  input  logic  local_wake,
  output mode_e mode_q,
  output logic  wake_flag,
  output logic  wake_local
);
  mode_e nxt;
  logic  wake_any;

  assign wake_any = bus_wake || local_wake;

  always_comb begin
    nxt = mode_q;
    unique case (mode_q)
      MODE_OFF:  nxt = MODE_SAFE;
      MODE_SAFE: if (en_f) nxt = MODE_RUN;
      MODE_RUN:  if (en_fall && txd_pin) nxt = MODE_DOZE;
      MODE_DOZE: if (wake_any) nxt = MODE_SAFE;
      default:   nxt = MODE_OFF;
    endcase
    if (!supply_ok) nxt = MODE_OFF;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= MODE_OFF;
    else        mode_q <= nxt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !supply_ok) begin
      wake_flag  <= 1'b0;
      wake_local <= 1'b0;
    end else if (mode_q == MODE_DOZE && wake_any) begin
      wake_flag  <= 1'b1;
      wake_local <= local_wake;
    end else if (en_pin) begin
      wake_flag  <= 1'b0;
      wake_local <= 1'b0;
    end
  end

  // R2
  supply_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (mode_q == MODE_OFF && !wake_flag));
  // R3
  power_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_OFF && supply_ok) |=> mode_q == MODE_SAFE);
  // R7
  sleep_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_RUN && en_fall && !txd_pin && supply_ok) |=> mode_q == MODE_RUN);
  // R8
  local_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_DOZE && local_wake && supply_ok) |=> (wake_flag && wake_local && mode_q == MODE_SAFE));
  // R11
  wake_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_flag) |-> $past(mode_q) == MODE_DOZE);
endmodule

// File: rtl/lmc_top.sv
module lmc_top
  import lmc_pkg::*;
#(
  parameter int CLK_PER_US = 250,
  parameter int NORM_US    = 7,
  parameter int SLEEP_US   = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       en_pin,
  input  logic       txd_pin,
  input  logic       bus_wake,
  input  logic       local_wake,
  output logic       inh_on,
  output logic       comm_en,
  output logic       rxd_wake_low,
  output logic       txd_strong_pd,
  output logic [1:0] mode
);
  logic  en_f, en_fall, wake_flag, wake_local;
  mode_e mode_q;

  lmc_en_filter #(.CLK_PER_US(CLK_PER_US), .NORM_US(NORM_US), .SLEEP_US(SLEEP_US)) u_filt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (!supply_ok),
    .en_pin  (en_pin),
    .en_f    (en_f),
    .en_fall (en_fall)
  );

  lmc_mode_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .supply_ok  (supply_ok),
    .en_pin     (en_pin),
    .txd_pin    (txd_pin),
    .en_f       (en_f),
    .en_fall    (en_fall),
    .bus_wake   (bus_wake),
    .local_wake (local_wake),
    .mode_q     (mode_q),
    .wake_flag  (wake_flag),
    .wake_local (wake_local)
  );

  assign mode          = mode_q;
  assign inh_on        = (mode_q == MODE_SAFE) || (mode_q == MODE_RUN);
  assign comm_en       = (mode_q == MODE_RUN);
  assign rxd_wake_low  = wake_flag && (mode_q == MODE_SAFE);
  assign txd_strong_pd = wake_flag && wake_local && (mode_q == MODE_SAFE);

  // R10
  wake_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_pin && mode_q != MODE_DOZE) |=> !rxd_wake_low);
endmodule

// File: tb/tb_lmc_top.sv
module tb_lmc_top;
  localparam int CPU = 4, NUS = 6, SUS = 5;
  localparam int N_RISE = NUS * CPU, N_FALL = SUS * CPU;

  logic clk = 1'b0, rst_n = 1'b0;
  logic supply_ok = 0, en_pin = 0, txd_pin = 0, bus_wake = 0, local_wake = 0;
  logic inh_on, comm_en, rxd_wake_low, txd_strong_pd;
  logic [1:0] mode;

  int checks = 0, fails = 0;
  bit chk_on = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  lmc_top #(.CLK_PER_US(CPU), .NORM_US(NUS), .SLEEP_US(SUS)) dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .en_pin(en_pin), .txd_pin(txd_pin),
    .bus_wake(bus_wake), .local_wake(local_wake), .inh_on(inh_on), .comm_en(comm_en),
    .rxd_wake_low(rxd_wake_low), .txd_strong_pd(txd_strong_pd), .mode(mode));

  // reference model built from the requirements
  int m_mode = 0, m_cnt = 0;
  bit m_ef = 0, m_fall = 0, m_flag = 0, m_loc = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode <= 0; m_cnt <= 0; m_ef <= 0; m_fall <= 0; m_flag <= 0; m_loc <= 0;
    end else begin
      m_fall <= 0;
      if (!supply_ok) begin
        m_ef <= 0; m_cnt <= 0;
      end else if (en_pin != m_ef) begin
        if (m_cnt + 1 == (m_ef ? N_FALL : N_RISE)) begin
          m_ef <= en_pin; m_cnt <= 0; m_fall <= !en_pin;
        end else m_cnt <= m_cnt + 1;
      end else m_cnt <= 0;
      if (!supply_ok) begin
        m_mode <= 0; m_flag <= 0; m_loc <= 0;
      end else begin
        case (m_mode)
          0: m_mode <= 1;
          1: if (m_ef) m_mode <= 2;
          2: if (m_fall && txd_pin) m_mode <= 3;
          default: if (local_wake || bus_wake) m_mode <= 1;
        endcase
        if (m_mode == 3 && (local_wake || bus_wake)) begin
          m_flag <= 1; m_loc <= local_wake;
        end else if (en_pin) begin
          m_flag <= 0; m_loc <= 0;
        end
      end
    end
  end

  function automatic int f_inh(int m);  return (m == 1 || m == 2) ? 1 : 0; endfunction
  function automatic int f_comm(int m); return (m == 2) ? 1 : 0; endfunction
  function automatic int f_rxd(int m, bit fl); return (m == 1 && fl) ? 1 : 0; endfunction
  function automatic int f_pd(int m, bit fl, bit lc); return (m == 1 && fl && lc) ? 1 : 0; endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (chk_on) begin
    chk(cur_req, "mode", int'(mode), m_mode);
    chk(cur_req, "inh_on", int'(inh_on), f_inh(m_mode));
    chk(cur_req, "comm_en", int'(comm_en), f_comm(m_mode));
    chk(cur_req, "rxd_wake_low", int'(rxd_wake_low), f_rxd(m_mode, m_flag));
    chk(cur_req, "txd_strong_pd", int'(txd_strong_pd), f_pd(m_mode, m_flag, m_loc));
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_wake(bit lw, bit bw);
    local_wake = lw; bus_wake = bw;
    cyc(1);
    local_wake = 0; bus_wake = 0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R4: actual running expected finished");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    cyc(3);
    // R1 during reset
    chk("R1", "mode", int'(mode), 0);
    chk("R1", "inh_on", int'(inh_on), 0);
    chk("R1", "rxd_wake_low", int'(rxd_wake_low), 0);
    rst_n = 1; cyc(2);
    chk("R1", "mode no supply", int'(mode), 0);
    chk_on = 1;
    // R3 power-up
    cur_req = "R3"; supply_ok = 1; cyc(1);
    chk("R3", "mode", int'(mode), 1);
    chk("R3", "inh_on", int'(inh_on), 1);
    chk("R3", "txd_strong_pd", int'(txd_strong_pd), 0);
    // R4 short enable pulse
    cur_req = "R4"; en_pin = 1; cyc(N_RISE - 1); en_pin = 0; cyc(30);
    chk("R4", "mode after short pulse", int'(mode), 1);
    // R5 accepted rise
    cur_req = "R5"; en_pin = 1; cyc(N_RISE);
    chk("R5", "mode before accept", int'(mode), 1);
    cyc(1);
    chk("R5", "mode", int'(mode), 2);
    chk("R5", "comm_en", int'(comm_en), 1);
    // R7 fall with txd low
    cur_req = "R7"; txd_pin = 0; en_pin = 0; cyc(N_FALL + 1);
    chk("R7", "mode stays normal", int'(mode), 2);
    en_pin = 1; cyc(30); txd_pin = 1;
    // R6 sleep entry
    cur_req = "R6"; en_pin = 0; cyc(N_FALL);
    chk("R6", "mode before accept", int'(mode), 2);
    cyc(1);
    chk("R6", "mode", int'(mode), 3);
    chk("R6", "inh_on", int'(inh_on), 0);
    // R12 enable ignored in sleep
    cur_req = "R12"; en_pin = 1; cyc(30);
    chk("R12", "mode", int'(mode), 3);
    en_pin = 0; cyc(30);
    chk("R12", "mode after fall", int'(mode), 3);
    // R8 local wake, simultaneous with bus wake
    cur_req = "R8"; pulse_wake(1, 1);
    chk("R8", "mode", int'(mode), 1);
    chk("R8", "rxd_wake_low", int'(rxd_wake_low), 1);
    chk("R8", "txd_strong_pd", int'(txd_strong_pd), 1);
    cyc(5);
    chk("R8", "flag held", int'(rxd_wake_low), 1);
    // R10 flags clear on raw enable
    cur_req = "R10"; en_pin = 1; cyc(1);
    chk("R10", "rxd_wake_low", int'(rxd_wake_low), 0);
    chk("R10", "txd_strong_pd", int'(txd_strong_pd), 0);
    chk("R10", "mode still fail-safe", int'(mode), 1);
    cyc(N_RISE); en_pin = 0; cyc(N_FALL + 2);
    chk("R6", "mode back to sleep", int'(mode), 3);
    // R9 bus wake
    cur_req = "R9"; pulse_wake(0, 1);
    chk("R9", "mode", int'(mode), 1);
    chk("R9", "rxd_wake_low", int'(rxd_wake_low), 1);
    chk("R9", "txd_strong_pd", int'(txd_strong_pd), 0);
    // R11 wake outside sleep
    cur_req = "R11"; pulse_wake(1, 0); cyc(2);
    chk("R11", "mode", int'(mode), 1);
    chk("R11", "txd_strong_pd", int'(txd_strong_pd), 0);
    chk("R11", "rxd_wake_low", int'(rxd_wake_low), 1);
    // R2 supply drop from normal, filter restarts
    en_pin = 1; cyc(N_RISE + 2);
    cur_req = "R2"; supply_ok = 0; cyc(1);
    chk("R2", "mode", int'(mode), 0);
    chk("R2", "inh_on", int'(inh_on), 0);
    supply_ok = 1; cyc(N_RISE);
    chk("R2", "mode filter restarted", int'(mode), 1);
    cyc(1);
    chk("R2", "mode normal again", int'(mode), 2);
    // random phase against the model
    for (int i = 0; i < 80; i++) begin
      int op;
      op = int'($urandom % 6);
      case (op)
        0: begin cur_req = "R4"; en_pin = ~en_pin; cyc(int'($urandom_range(1, 40))); end
        1: begin cur_req = "R7"; txd_pin = 1'($urandom); cyc(1); end
        2: begin cur_req = "R9"; pulse_wake(0, 1); end
        3: begin cur_req = "R8"; pulse_wake(1, 0); end
        4: begin cur_req = "R11"; pulse_wake(1, 1); end
        default: begin
          cur_req = "R2"; supply_ok = 0; cyc(int'($urandom_range(1, 3))); supply_ok = 1;
        end
      endcase
      cyc(int'($urandom_range(1, 40)));
    end
    chk_on = 0;
    summary();
  end
endmodule